// File: doc/BRIEF.md
# Ring-Carry Ones-Complement Adder

This block adds two N-bit operands in ones-complement arithmetic in a single combinational step. The carry that leaves the top bit in a plain binary add has to come back in at bit 0. Here that end-around carry is not handled by a second add. The carry network is closed into a ring instead: the carry into any bit is a lookahead term built from all the other positions, taken in circular order. As a result, every bit position has the same logic form, and there is no special low or high end.

The block has no clock and no state. It is meant to sit inside checksum accumulators or header-update logic wherever a wrap-around sum of two words is needed. The width is a parameter, with a default of 16. The carry ring comes in two arrangements:

- **Flat ring:** one lookahead term per bit, spanning the whole word.
- **Sliced ring:** the word is cut into fixed-size slices. A ring of slice-level generate/propagate terms feeds each slice's carry-in. Each slice then resolves its own bits. In this arrangement the width must be a whole multiple of the slice size.

Top module: `ocRingAdder`

## Requirements
- R1: `sum` equals the low N bits of (opA + opB) computed as an unsigned binary add, with that add's carry-out then added into bit 0.
- R2: The carry entering bit 0 equals the carry-out of the plain binary add of the two operands (the end-around carry).
- R3: When opB is the bitwise complement of opA, `sum` is all ones (negative zero).
- R4: When opB is all zeros, `sum` equals opA for every opA, including opA all ones.
- R5: When opA is all ones and opB is not all zeros, `sum` equals opB.
- R6: `sum` is all zeros only when both operands are all zeros; with both operands zero it is zero.
- R7: Swapping opA and opB leaves `sum` unchanged.
- R8: The flat-ring and sliced-ring arrangements give identical sums for identical operands at 16 bits.
- R9: A 4-bit instance produces the R1 result for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sum | output | WIDTH | Ones-complement sum of the operands |

## Verification
The built-in checks evaluate continuously on the settled combinational outputs. They take for granted that the operands are two-state values that hold steady while they are looked at; the block itself places no other condition on its inputs. The stimulus changes the operands only on the falling clock edge and compares results on the following rising edge, so every check sees settled values. The stimulus covers:

- the corner words 0x0000, 0xFFFF, 0x8000, 0x7FFF and 0x0001 in all pairings;
- complement pairs, which must give negative zero;
- every 4-bit operand pair;
- random 16-bit pairs, each also applied in swapped order.

// File: rtl/ocPkg.sv
package ocPkg;
  // Carry ring arrangement
  typedef enum logic {
    RING_FLAT   = 1'b0,
    RING_SLICED = 1'b1
  } ringStyleE;
endpackage

// File: rtl/ocGenProp.sv
module ocGenProp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  // Generate: both bits set. Propagate: either bit set (the OR form is
  // safe because generate dominates whenever both are high).
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign gen[i]  = opA[i] & opB[i];
    assign prop[i] = opA[i] | opB[i];
  end
endmodule

// File: rtl/ocFlatRing.sv
module ocFlatRing #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] cin
);
  // Carry into position j: walk backwards around the ring through every
  // other position (and finally j itself), OR-ing each generate that can
  // reach j through an unbroken run of propagates.
  always_comb begin
    logic acc;
    logic run;
    int   idx;
    cin = '0;
    for (int j = 0; j < WIDTH; j++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int m = 1; m <= WIDTH; m++) begin
        idx = (j - m + WIDTH) % WIDTH;
        acc = acc | (run & gen[idx]);
        run = run & prop[idx];
      end
      cin[j] = acc;
    end
  end
endmodule

// File: rtl/ocSliceRing.sv
module ocSliceRing #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] cin
);
  localparam int NSLICE = WIDTH / SLICE;

  if (WIDTH % SLICE != 0) begin : gBadWidth
    $error("ocSliceRing: WIDTH must be a multiple of SLICE");
  end

  logic [NSLICE-1:0] grpGen;
  logic [NSLICE-1:0] grpProp;
  logic [NSLICE-1:0] grpCin;

  // Slice-level generate and propagate
  always_comb begin
    logic gg;
    logic pp;
    grpGen  = '0;
    grpProp = '0;
    for (int k = 0; k < NSLICE; k++) begin
      gg = 1'b0;
      pp = 1'b1;
      for (int i = 0; i < SLICE; i++) begin
        gg = gen[k*SLICE+i] | (prop[k*SLICE+i] & gg);
        pp = pp & prop[k*SLICE+i];
      end
      grpGen[k]  = gg;
      grpProp[k] = pp;
    end
  end

  // Ring across slices
  ocFlatRing #(.WIDTH(NSLICE)) uGroupRing (
    .gen  (grpGen),
    .prop (grpProp),
    .cin  (grpCin)
  );

  // Resolve bits inside each slice from the slice carry-in
  always_comb begin
    logic c;
    cin = '0;
    for (int k = 0; k < NSLICE; k++) begin
      c = grpCin[k];
      for (int i = 0; i < SLICE; i++) begin
        cin[k*SLICE+i] = c;
        c = gen[k*SLICE+i] | (prop[k*SLICE+i] & c);
      end
    end
  end
endmodule

// File: rtl/ocRingAdder.sv
module ocRingAdder #(
  parameter int               WIDTH = 16,
  parameter int               SLICE = 4,
  parameter ocPkg::ringStyleE STYLE = ocPkg::RING_SLICED
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] carryIn;

  ocGenProp #(.WIDTH(WIDTH)) uGp (
    .opA  (opA),
    .opB  (opB),
    .gen  (gen),
    .prop (prop)
  );

  if (STYLE == ocPkg::RING_SLICED) begin : gSliced
    ocSliceRing #(.WIDTH(WIDTH), .SLICE(SLICE)) uRing (
      .gen  (gen),
      .prop (prop),
      .cin  (carryIn)
    );
  end else begin : gFlat
    ocFlatRing #(.WIDTH(WIDTH)) uRing (
      .gen  (gen),
      .prop (prop),
      .cin  (carryIn)
    );
  end

  assign sum = opA ^ opB ^ carryIn;

  // Checks on settled combinational values
  always_comb begin
    logic [WIDTH:0] wide;
    wide = {1'b0, opA} + {1'b0, opB};
    // R2: ring carry into bit 0 matches the binary add's carry-out
    a_r2_wrap_carry: assert (carryIn[0] == wide[WIDTH]);
    // R3: complement pair gives negative zero
    if (opA == ~opB) begin
      a_r3_neg_zero: assert (sum == {WIDTH{1'b1}});
    end
    // R4: adding positive zero is identity
    if (opB == '0) begin
      a_r4_add_zero: assert (sum == opA);
    end
    // R5: negative zero plus nonzero word returns that word
    if (opA == {WIDTH{1'b1}} && opB != '0) begin
      a_r5_add_negzero: assert (sum == opB);
    end
    // R6: all-zero result only from two zero operands
    if (sum == '0) begin
      a_r6_pos_zero: assert (opA == '0 && opB == '0);
    end
  end
endmodule

// File: tb/sim_ocRingAdder.sv
module sim_ocRingAdder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a16, b16, s16Sliced, s16Flat;
  logic [3:0]  a4, b4, s4;

  ocRingAdder #(.WIDTH(16), .SLICE(4), .STYLE(ocPkg::RING_SLICED)) u0 (
    .opA(a16), .opB(b16), .sum(s16Sliced));
  ocRingAdder #(.WIDTH(16), .SLICE(4), .STYLE(ocPkg::RING_FLAT)) u1 (
    .opA(a16), .opB(b16), .sum(s16Flat));
  ocRingAdder #(.WIDTH(4), .SLICE(4), .STYLE(ocPkg::RING_FLAT)) u2 (
    .opA(a4), .opB(b4), .sum(s4));

  typedef struct {
    logic [15:0] exp16;
    logic [3:0]  exp4;
    string       tag;
  } itemT;

  itemT q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [15:0] ref16(logic [15:0] a, logic [15:0] b);
    logic [16:0] c;
    c = {1'b0, a} + {1'b0, b};
    return c[15:0] + {15'b0, c[16]};
  endfunction

  function automatic logic [3:0] ref4(logic [3:0] a, logic [3:0] b);
    logic [4:0] c;
    c = {1'b0, a} + {1'b0, b};
    return c[3:0] + {3'b0, c[4]};
  endfunction

  function automatic string tagFor(logic [15:0] a, logic [15:0] b);
    if (a == 16'h0000 && b == 16'h0000) return "R6";
    if (b == 16'h0000) return "R4";
    if (a == 16'hFFFF) return "R5";
    if (a == ~b) return "R3";
    return "R1";
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] x, input logic [3:0] y,
                       input string tag);
    itemT it;
    @(negedge clk);
    a16 = a; b16 = b; a4 = x; b4 = y;
    it.exp16 = ref16(a, b);
    it.exp4  = ref4(x, y);
    it.tag   = tag;
    q.push_back(it);
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      itemT it;
      it = q.pop_front();
      checks += 3;
      if (s16Sliced !== it.exp16) begin
        failures++;
        $display("FAIL %s sliced16 a=%h b=%h actual=%h expected=%h",
                 it.tag, a16, b16, s16Sliced, it.exp16);
      end
      if (s16Flat !== s16Sliced || s16Flat !== it.exp16) begin
        failures++;
        $display("FAIL R8 flat16 a=%h b=%h actual=%h expected=%h",
                 a16, b16, s16Flat, it.exp16);
      end
      if (s4 !== it.exp4) begin
        failures++;
        $display("FAIL R9 w4 a=%h b=%h actual=%h expected=%h",
                 a4, b4, s4, it.exp4);
      end
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [15:0] corners [5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001};

  initial begin
    a16 = '0; b16 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R6: state straight after reset, both operands zero -> zero
    drive(16'h0000, 16'h0000, 4'h0, 4'h0, "R6");

    // Corner words in every pairing (R1, R3, R4, R5 by tag)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        drive(corners[i], corners[j], corners[i][3:0], corners[j][3:0],
              tagFor(corners[i], corners[j]));

    // R3: complement pairs
    for (int i = 0; i < 40; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      drive(r, ~r, r[3:0], ~r[3:0], "R3");
    end

    // R9: every 4-bit pair, with random 16-bit operands alongside (R1)
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        logic [15:0] ra, rb;
        ra = 16'($urandom);
        rb = 16'($urandom);
        drive(ra, rb, 4'(x), 4'(y), tagFor(ra, rb));
      end

    // R1 random, each pair followed by its swap for R7
    for (int i = 0; i < 600; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (i % 7 == 0) ? 16'hFFFF - ra + 16'h0001 : 16'($urandom);
      drive(ra, rb, ra[3:0], rb[3:0], tagFor(ra, rb));
      drive(rb, ra, rb[3:0], ra[3:0], "R7");
    end

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule